// File: doc/BRIEF.md
# Synchronous Burst SRAM Core

This block is a clocked single-port static memory meant to hold the data of a secondary cache. Every input except output enable is sampled on the rising clock edge: the address, the write data, the write strobe, both chip selects, both burst-start strobes and the burst-advance strobe. An external address is needed only when a burst begins. After that, a small counter inside the block supplies the low address bits of each following word of the cache line. The counter steps in linear order and wraps within the line.

A burst is opened by either of two active-low start strobes. One belongs to the processor and one to the cache controller. The advance strobe then moves the access to the next word. When it is inactive, the same word is accessed again. Writes complete at the clock edge that ends the registered cycle, so no external write pulse is needed. Read data leaves an output register one clock after its address was captured. The shared data pins are modelled as a separate input bus, an output bus and a drive-enable. The drive-enable also follows the asynchronous output-enable pin.

In the target configuration the address is 15 bits wide (32,768 words of 9 bits). `ADDR_W` selects this. The default elaboration uses a smaller array so that it stays light.

Top module: `sbs_sram`

## Requirements
- R1: A cycle registered with both chip selects active and `wr_n` low writes the registered `din` into the word at the current access address, which is {upper bits, burst offset}, at the next rising edge.
- R2: A cycle registered with both selects active and `wr_n` high places the word at the current access address on `dout` after the following rising edge.
- R3: When the device is selected, an active-low `go_cpu_n` or `go_ctl_n` loads the full external address: the upper bits become the line base and the low 2 bits become the burst offset.
- R4: When the device is selected, `step_n` is low and no start is active, the burst offset advances by one modulo 4 (for example 3 to 0). The upper address bits stay unchanged.
- R5: With no start and `step_n` high, the access address is held, so the same word is accessed again.
- R6: When a start and `step_n` are active in the same cycle, the start wins: the offset takes the low 2 bits of `addr` and does not advance.
- R7: The device responds only when `cs_hi` is high and `cs_lo_n` is low. A deselected cycle writes nothing, ignores starts and advances, and does not drive `dout` in the following cycle.
- R8: `dout_oe` is high only while `oe_n` is low and the output register holds data from a selected read. `oe_n` acts without waiting for a clock edge.
- R9: After reset, `dout_oe` is low and the access address is 0 until the first start.
- R10: In the cycle after a registered write, `dout_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | External word address, used at burst start |
| din | input | DATA_W | Write data |
| wr_n | input | 1 | Active-low write strobe |
| cs_hi | input | 1 | Active-high chip select |
| cs_lo_n | input | 1 | Active-low chip select |
| go_cpu_n | input | 1 | Active-low burst start from the processor |
| go_ctl_n | input | 1 | Active-low burst start from the cache controller |
| step_n | input | 1 | Active-low burst advance |
| oe_n | input | 1 | Asynchronous active-low output enable |
| dout | output | DATA_W | Registered read data |
| dout_oe | output | 1 | Drive-enable for the shared data pins |

## Verification
A burst offset that is wrong or steps wrongly makes writes land on the wrong word. This shows at the ports only when that word is read back, which is one clock after the read is registered. The bench therefore writes whole wrapped bursts and reads them back from a different starting offset. A stale select or write flag shows at once as a wrong `dout_oe` in the next cycle. A fault in the output-enable gating shows within the same cycle, because `oe_n` is toggled between clock edges.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  // Linear next offset inside a line of 2**width words, wrapping at the end.
  function automatic int unsigned burst_next(int unsigned off, int unsigned width);
    return (off + 1) % (32'd1 << width);
  endfunction
endpackage

// File: rtl/sbs_ctrl.sv
module sbs_ctrl #(
  parameter int ADDR_W  = 10,
  parameter int DATA_W  = 9,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              wr_n,
  input  logic              cs_hi,
  input  logic              cs_lo_n,
  input  logic              go_cpu_n,
  input  logic              go_ctl_n,
  input  logic              step_n,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              cyc_sel,
  output logic              cyc_wr
);
  import sbs_pkg::*;
  localparam int HI_W = ADDR_W - BURST_W;

  logic [HI_W-1:0]    line_base;
  logic [BURST_W-1:0] offset;

  // Named events for the assertions.
  logic sel_now, start_now, adv_now, hold_now;
  assign sel_now   = cs_hi & ~cs_lo_n;
  assign start_now = sel_now & (~go_cpu_n | ~go_ctl_n);
  assign adv_now   = sel_now & ~step_n & ~start_now;
  assign hold_now  = ~start_now & ~adv_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_base <= '0;
      offset    <= '0;
      cyc_sel   <= 1'b0;
      cyc_wr    <= 1'b0;
      wr_data   <= '0;
    end else begin
      cyc_sel <= sel_now;
      cyc_wr  <= sel_now & ~wr_n;
      wr_data <= din;
      if (start_now) begin
        line_base <= addr[ADDR_W-1:BURST_W];
        offset    <= addr[BURST_W-1:0];
      end else if (adv_now) begin
        offset <= BURST_W'(burst_next(int'(offset), BURST_W));
      end
    end
  end

  assign acc_addr = {line_base, offset};

  // R4: advance moves the offset by one with wrap, line base unchanged
  a_r4_advance_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    adv_now |=> (offset == $past(offset) + BURST_W'(1)) && $stable(line_base));

  // R5: no start and no advance keeps the access address
  a_r5_hold_address: assert property (@(posedge clk) disable iff (!rst_n)
    hold_now |=> $stable(acc_addr));

  // R6: a start beats a simultaneous advance
  a_r6_start_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (start_now && !step_n) |=> acc_addr == $past(addr));

  // R7: a deselected cycle registers no access
  a_r7_desel_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_now |=> !cyc_sel && !cyc_wr && $stable(acc_addr));
endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cyc_sel,
  input  logic              cyc_wr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  logic wr_go, rd_go;
  assign wr_go = cyc_sel & cyc_wr;
  assign rd_go = cyc_sel & ~cyc_wr;

  // Write completes on the edge that closes the registered cycle.
  always_ff @(posedge clk) begin
    if (wr_go) mem[acc_addr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_go;
      if (rd_go) rd_data <= mem[acc_addr];
    end
  end

  // R2: a selected read fills the output register one edge later
  a_r2_read_lands: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |=> rd_valid);

  // R10: a write leaves the output undriven in the next cycle
  a_r10_write_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |=> !rd_valid);
endmodule

// File: rtl/sbs_sram.sv
module sbs_sram #(
  parameter int ADDR_W  = 10,
  parameter int DATA_W  = 9,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              wr_n,
  input  logic              cs_hi,
  input  logic              cs_lo_n,
  input  logic              go_cpu_n,
  input  logic              go_ctl_n,
  input  logic              step_n,
  input  logic              oe_n,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe
);
  logic [ADDR_W-1:0] acc_addr;
  logic [DATA_W-1:0] wr_data;
  logic              cyc_sel, cyc_wr, rd_valid;

  sbs_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BURST_W(BURST_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .wr_n(wr_n),
    .cs_hi(cs_hi), .cs_lo_n(cs_lo_n), .go_cpu_n(go_cpu_n), .go_ctl_n(go_ctl_n),
    .step_n(step_n), .acc_addr(acc_addr), .wr_data(wr_data),
    .cyc_sel(cyc_sel), .cyc_wr(cyc_wr)
  );

  sbs_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) array_i (
    .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .wr_data(wr_data),
    .cyc_sel(cyc_sel), .cyc_wr(cyc_wr), .rd_data(dout), .rd_valid(rd_valid)
  );

  // Output enable is combinational: no clock between oe_n and the drive.
  assign dout_oe = rd_valid & ~oe_n;

  // R8: the pins are driven only under an active output enable
  a_r8_drive_needs_oe: assert property (@(posedge clk) disable iff (!rst_n)
    dout_oe |-> !oe_n && rd_valid);
endmodule

// File: tb/sbs_sram_tb_top.sv
`timescale 1ns/1ps
module sbs_sram_tb_top;
  localparam int AW = 10;
  localparam int DW = 9;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] din;
  logic          wr_n, cs_hi, cs_lo_n, go_cpu_n, go_ctl_n, step_n, oe_n;
  logic [DW-1:0] dout;
  logic          dout_oe;

  always #2 clk = ~clk;

  sbs_sram #(.ADDR_W(AW), .DATA_W(DW), .BURST_W(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .wr_n(wr_n),
    .cs_hi(cs_hi), .cs_lo_n(cs_lo_n), .go_cpu_n(go_cpu_n), .go_ctl_n(go_ctl_n),
    .step_n(step_n), .oe_n(oe_n), .dout(dout), .dout_oe(dout_oe)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  // Behavioural reference state
  logic [DW-1:0] ref_mem [int];
  int  m_base, m_off, m_din;
  bit  m_sel, m_we, m_rdv, m_known;
  int  m_dout;

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_base = 0; m_off = 0; m_sel = 0; m_we = 0; m_rdv = 0; m_known = 0;
    m_dout = 0; m_din = 0;
  endtask

  // One clock cycle: drive now (just after a falling edge), model the rising
  // edge, compare at the next falling edge.
  task automatic cyc(int a, int d, bit we, bit sel, bit scpu, bit sctl,
                     bit adv, bit oe, string tag);
    int acc;
    bit exp_oe;
    addr = AW'(a); din = DW'(d); wr_n = ~we;
    cs_hi = sel; cs_lo_n = ~sel; go_cpu_n = ~scpu; go_ctl_n = ~sctl;
    step_n = ~adv; oe_n = ~oe;
    @(posedge clk);
    acc = m_base * 4 + m_off;
    if (m_sel && m_we) ref_mem[acc] = DW'(m_din);
    m_rdv = m_sel && !m_we;
    if (m_rdv) begin
      m_known = ref_mem.exists(acc);
      m_dout  = m_known ? int'(ref_mem[acc]) : 0;
    end
    m_sel = sel; m_we = sel && we; m_din = d;
    if (sel && (scpu || sctl)) begin
      m_base = a / 4; m_off = a % 4;
    end else if (sel && adv) begin
      m_off = (m_off + 1) % 4;
    end
    @(negedge clk);
    exp_oe = oe && m_rdv;
    check(dout_oe == exp_oe, {tag, " dout_oe"}, int'(dout_oe), int'(exp_oe));
    if (exp_oe && m_known)
      check(dout == DW'(m_dout), {tag, " dout"}, int'(dout), m_dout);
  endtask

  task automatic idle(string tag);
    cyc(0, 0, 0, 0, 0, 0, 0, 1, tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    addr = '0; din = '0; wr_n = 1; cs_hi = 0; cs_lo_n = 1;
    go_cpu_n = 1; go_ctl_n = 1; step_n = 1; oe_n = 0;
    model_reset();
    repeat (3) @(negedge clk);
    check(dout_oe == 1'b0, "R9 reset drive", int'(dout_oe), 0);
    rst_n = 1'b1;
  endtask

  initial begin
    do_reset();
    // Seed word 0 for the post-reset address check (R9), via controller start (R3)
    cyc(0, 9'h155, 1, 1, 0, 1, 0, 1, "R3 R1 seed word0");
    idle("R10 after write");
    // Write burst starting at offset 1 via processor start, wrapping (R1 R4)
    cyc('h2A1, 9'h011, 1, 1, 1, 0, 0, 1, "R1 burst w0");
    cyc(0, 9'h022, 1, 1, 0, 0, 1, 1, "R4 burst w1");
    cyc(0, 9'h033, 1, 1, 0, 0, 1, 1, "R4 burst w2");
    cyc(0, 9'h044, 1, 1, 0, 0, 1, 1, "R4 wrap w3");
    // Read back from offset 2 via controller start (R2 R3 R4)
    cyc('h2A2, 0, 0, 1, 0, 1, 0, 1, "R10 R3 read start");
    cyc(0, 0, 0, 1, 0, 0, 1, 1, "R2 read +1");
    cyc(0, 0, 0, 1, 0, 0, 1, 1, "R4 read wrap");
    cyc(0, 0, 0, 1, 0, 0, 1, 1, "R4 read +3");
    // Hold: advance inactive reads same word (R5)
    cyc(0, 0, 0, 1, 0, 0, 0, 1, "R5 hold a");
    cyc(0, 0, 0, 1, 0, 0, 0, 1, "R5 hold b");
    // Async output enable (R8)
    oe_n = 1'b1; #1;
    check(dout_oe == 1'b0, "R8 oe off async", int'(dout_oe), 0);
    oe_n = 1'b0; #1;
    check(dout_oe == 1'b1, "R8 oe on async", int'(dout_oe), 1);
    cyc(0, 0, 0, 1, 0, 0, 0, 0, "R8 oe held off");
    // Start with advance in the same cycle: start wins (R6)
    cyc('h2A3, 0, 0, 1, 1, 0, 1, 1, "R6 start+adv");
    cyc(0, 0, 0, 1, 0, 0, 0, 1, "R6 read loaded");
    cyc('h2A0, 0, 0, 1, 0, 1, 1, 1, "R6 ctl start+adv");
    cyc(0, 0, 0, 1, 0, 0, 0, 1, "R6 read loaded2");
    // Deselected: write and start ignored, counter held (R7)
    cyc('h100, 9'h1FF, 1, 0, 1, 1, 1, 1, "R7 desel write");
    cyc('h2A0, 9'h1EE, 1, 0, 1, 0, 0, 1, "R7 desel start");
    cyc(0, 0, 0, 1, 0, 0, 0, 1, "R7 held addr read");
    cyc(0, 0, 0, 1, 0, 0, 0, 1, "R7 held addr read2");
    // Only one select active counts as deselected (R7)
    addr = 'h2A1; din = 9'h0AB; wr_n = 0; cs_hi = 1; cs_lo_n = 1;
    go_cpu_n = 0; go_ctl_n = 1; step_n = 1; oe_n = 0;
    @(posedge clk); m_rdv = m_sel && !m_we;
    if (m_rdv) begin m_known = ref_mem.exists(m_base*4+m_off); m_dout = m_known ? int'(ref_mem[m_base*4+m_off]) : 0; end
    m_sel = 0; m_we = 0;
    @(negedge clk);
    cyc('h2A1, 0, 0, 1, 1, 0, 0, 1, "R7 half select");
    check(dout_oe == 1'b0, "R7 no drive after desel", int'(dout_oe), 0);
    cyc(0, 0, 0, 1, 0, 0, 0, 1, "R7 word kept");
    // Reset again: access address returns to 0 (R9)
    do_reset();
    cyc(0, 0, 0, 1, 0, 0, 0, 1, "R9 first read");
    cyc(0, 0, 0, 1, 0, 0, 0, 1, "R9 word0 value");
    check(dout == 9'h155, "R9 post-reset addr0", int'(dout), 'h155);
    idle("end idle");
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule